// File: doc/BRIEF.md
# Shared high-byte snapshot read latch

This block lets an 8-bit processor bus read two 16-bit quantities without tearing. One is a live down-counter value and the other is a capture register. The block decodes a small read address space. A read of either low byte returns that byte at once. In the same clock cycle it stores the matching upper byte in one holding register, which both sources share. A later read of either high-byte address returns the stored byte instead of the live upper byte. Software therefore reads low first and high second, and gets a 16-bit value whose two halves come from the same clock edge.

The counter and the capture logic are outside the block. They arrive as plain 16-bit inputs. Read data is combinational from the address while the strobe is high. The only state is the holding register. Its reset style (asynchronous or synchronous) is chosen by a parameter.

Top module: `snap_read_port`

## Requirements
- R1: After reset the holding register is 0x00, so a high-byte read before any low-byte read returns 0x00.
- R2: A strobed read of address 0 (counter low) returns bits 7:0 of the counter input in the same cycle.
- R3: A strobed read of address 0 loads bits 15:8 of the counter input, as sampled at that clock edge, into the holding register.
- R4: A strobed read of address 2 (capture low) returns bits 7:0 of the capture input in the same cycle.
- R5: A strobed read of address 2 loads bits 15:8 of the capture input into the holding register.
- R6: Strobed reads of address 1 (counter high) and address 3 (capture high) both return the holding register, whichever low byte loaded it.
- R7: A high-byte read leaves the holding register unchanged.
- R8: With the strobe low, the read data is 0x00 and the holding register is not loaded, whatever the address.
- R9: The upper byte returned by a low-then-high sequence is the one present when the low byte was read, even if the counter input later moves across a byte boundary.
- R10: Reading the high address before the low address returns the byte left by the previous low-byte read (stale data).
- R11: A strobed read of an unmapped address (4 to 7) returns 0x00 and does not load the holding register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rd_en | input | 1 | Single-cycle read strobe |
| rd_addr | input | 3 | Read address |
| cnt_val | input | 16 | Live down-counter value |
| cap_val | input | 16 | Capture register value |
| rd_data | output | 8 | Combinational read data |

## Verification
The sequences read the counter pair and the capture pair in the correct order. Each source is checked in turn to see which one fills the shared holding register, and whether both high addresses return it. Other cases change the counter input between the low and high reads, including a jump that crosses the byte boundary. These separate a true snapshot from a live pass-through. Reversed reads, unstrobed reads, unmapped addresses and repeated high reads confirm that only a strobed low-byte read changes the stored byte. A reset during a run confirms that the holding register clears.

// File: rtl/snap_pkg.sv
package snap_pkg;
   typedef enum logic [2:0] {
      SEL_NONE   = 3'd0,
      SEL_CNT_LO = 3'd1,
      SEL_CNT_HI = 3'd2,
      SEL_CAP_LO = 3'd3,
      SEL_CAP_HI = 3'd4
   } snap_sel_e;
endpackage

// File: rtl/snap_addr_decode.sv
module snap_addr_decode
   import snap_pkg::*;
#(
   parameter int ADDR_W      = 3,
   parameter int OFF_CNT_LO  = 0,
   parameter int OFF_CNT_HI  = 1,
   parameter int OFF_CAP_LO  = 2,
   parameter int OFF_CAP_HI  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output snap_sel_e         sel
);
   localparam int NUM_REGS = 4;
   localparam logic [ADDR_W-1:0] A_CL = ADDR_W'(OFF_CNT_LO);
   localparam logic [ADDR_W-1:0] A_CH = ADDR_W'(OFF_CNT_HI);
   localparam logic [ADDR_W-1:0] A_PL = ADDR_W'(OFF_CAP_LO);
   localparam logic [ADDR_W-1:0] A_PH = ADDR_W'(OFF_CAP_HI);

   generate
      if ((1 << ADDR_W) < NUM_REGS) begin : g_bad_aw
         $error("snap_addr_decode: address space too small");
      end
      if (OFF_CNT_LO == OFF_CNT_HI || OFF_CNT_LO == OFF_CAP_LO ||
          OFF_CNT_LO == OFF_CAP_HI || OFF_CNT_HI == OFF_CAP_LO ||
          OFF_CNT_HI == OFF_CAP_HI || OFF_CAP_LO == OFF_CAP_HI) begin : g_bad_map
         $error("snap_addr_decode: offsets must differ");
      end
   endgenerate

   logic [NUM_REGS-1:0] hit;

   always_comb begin
      hit[0] = rd_en && (rd_addr == A_CL);
      hit[1] = rd_en && (rd_addr == A_CH);
      hit[2] = rd_en && (rd_addr == A_PL);
      hit[3] = rd_en && (rd_addr == A_PH);
   end

   always_comb begin
      unique case (1'b1)
         hit[0]:  sel = SEL_CNT_LO;
         hit[1]:  sel = SEL_CNT_HI;
         hit[2]:  sel = SEL_CAP_LO;
         hit[3]:  sel = SEL_CAP_HI;
         default: sel = SEL_NONE;
      endcase
   end

   // R8: no strobe, no selection
   assert_idle_no_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> sel == SEL_NONE);
   // R11: at most one register decoded per access
   assert_one_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));
endmodule

// File: rtl/snap_hold_reg.sv
module snap_hold_reg #(
   parameter int   DATA_W     = 8,
   parameter bit   SYNC_RESET = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] q
);
   localparam logic [DATA_W-1:0] RST_VAL = '0;

   generate
      if (DATA_W < 1) begin : g_bad_w
         $error("snap_hold_reg: DATA_W must be positive");
      end
      if (SYNC_RESET) begin : g_sync
         always_ff @(posedge clk) begin
            if (!rst_n)    q <= RST_VAL;
            else if (load) q <= din;
         end
      end else begin : g_async
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    q <= RST_VAL;
            else if (load) q <= din;
         end
      end
   endgenerate

   // R7, R8, R11: without a load the stored byte holds
   assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));
endmodule

// File: rtl/snap_rd_mux.sv
module snap_rd_mux
   import snap_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  snap_sel_e         sel,
   input  logic [DATA_W-1:0] cnt_lo,
   input  logic [DATA_W-1:0] cap_lo,
   input  logic [DATA_W-1:0] held,
   output logic [DATA_W-1:0] rd_data
);
   always_comb begin
      unique case (sel)
         SEL_CNT_LO: rd_data = cnt_lo;
         SEL_CAP_LO: rd_data = cap_lo;
         SEL_CNT_HI,
         SEL_CAP_HI: rd_data = held;
         default:    rd_data = '0;
      endcase
   end
endmodule

// File: rtl/snap_read_port.sv
module snap_read_port
   import snap_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int VALUE_W    = 16,
   parameter int ADDR_W     = 3,
   parameter int OFF_CNT_LO = 0,
   parameter int OFF_CNT_HI = 1,
   parameter int OFF_CAP_LO = 2,
   parameter int OFF_CAP_HI = 3,
   parameter bit SYNC_RESET = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  rd_addr,
   input  logic [VALUE_W-1:0] cnt_val,
   input  logic [VALUE_W-1:0] cap_val,
   output logic [DATA_W-1:0]  rd_data
);
   localparam int HI_LSB = VALUE_W - DATA_W;

   generate
      if (VALUE_W != 2 * DATA_W) begin : g_bad_split
         $error("snap_read_port: VALUE_W must be two bytes of DATA_W");
      end
   endgenerate

   snap_sel_e         sel;
   logic              hold_load;
   logic [DATA_W-1:0] hold_din;
   logic [DATA_W-1:0] hold_q;

   snap_addr_decode #(
      .ADDR_W    (ADDR_W),
      .OFF_CNT_LO(OFF_CNT_LO),
      .OFF_CNT_HI(OFF_CNT_HI),
      .OFF_CAP_LO(OFF_CAP_LO),
      .OFF_CAP_HI(OFF_CAP_HI)
   ) u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_en  (rd_en),
      .rd_addr(rd_addr),
      .sel    (sel)
   );

   always_comb begin
      hold_load = (sel == SEL_CNT_LO) || (sel == SEL_CAP_LO);
      hold_din  = (sel == SEL_CAP_LO) ? cap_val[HI_LSB +: DATA_W]
                                      : cnt_val[HI_LSB +: DATA_W];
   end

   snap_hold_reg #(
      .DATA_W    (DATA_W),
      .SYNC_RESET(SYNC_RESET)
   ) u_hold (
      .clk  (clk),
      .rst_n(rst_n),
      .load (hold_load),
      .din  (hold_din),
      .q    (hold_q)
   );

   snap_rd_mux #(
      .DATA_W(DATA_W)
   ) u_mux (
      .sel    (sel),
      .cnt_lo (cnt_val[DATA_W-1:0]),
      .cap_lo (cap_val[DATA_W-1:0]),
      .held   (hold_q),
      .rd_data(rd_data)
   );

   localparam logic [ADDR_W-1:0] A_CL = ADDR_W'(OFF_CNT_LO);
   localparam logic [ADDR_W-1:0] A_CH = ADDR_W'(OFF_CNT_HI);
   localparam logic [ADDR_W-1:0] A_PL = ADDR_W'(OFF_CAP_LO);
   localparam logic [ADDR_W-1:0] A_PH = ADDR_W'(OFF_CAP_HI);

   assert_cnt_lo_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == A_CL) |-> rd_data == cnt_val[DATA_W-1:0]);
   assert_cnt_snapshot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == A_CL) |=> hold_q == $past(cnt_val[HI_LSB +: DATA_W]));
   assert_cap_lo_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == A_PL) |-> rd_data == cap_val[DATA_W-1:0]);
   assert_cap_snapshot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == A_PL) |=> hold_q == $past(cap_val[HI_LSB +: DATA_W]));
   assert_hi_shared_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (rd_addr == A_CH || rd_addr == A_PH)) |-> rd_data == hold_q);
   assert_hi_no_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (rd_addr == A_CH || rd_addr == A_PH)) |=> $stable(hold_q));
   assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> rd_data == '0);
endmodule

// File: tb/snap_read_port_bench.sv
module snap_read_port_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_en = 1'b0;
   logic [2:0]  rd_addr = '0;
   logic [15:0] cnt_val = '0;
   logic [15:0] cap_val = '0;
   logic [7:0]  rd_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   snap_read_port u_snap_read_port (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_en  (rd_en),
      .rd_addr(rd_addr),
      .cnt_val(cnt_val),
      .cap_val(cap_val),
      .rd_data(rd_data)
   );

   // fields: addr[47:45] rd[44] cnt[43:28] cap[27:12] exp[11:4] req[3:0]
   localparam int NV = 16;
   localparam logic [47:0] VEC [NV] = '{
      {3'd1, 1'b1, 16'h1234, 16'h0000, 8'h00, 4'd1},  // R1 reset value via cnt hi
      {3'd3, 1'b1, 16'h1234, 16'h5678, 8'h00, 4'd1},  // R1 reset value via cap hi
      {3'd0, 1'b1, 16'hA55A, 16'h5678, 8'h5A, 4'd2},  // R2 cnt lo, loads A5
      {3'd1, 1'b1, 16'h0000, 16'h5678, 8'hA5, 4'd3},  // R3 / R9 live cnt moved
      {3'd3, 1'b1, 16'h0000, 16'h5678, 8'hA5, 4'd6},  // R6 same byte at cap hi
      {3'd1, 1'b1, 16'hFFFF, 16'h5678, 8'hA5, 4'd7},  // R7 repeated hi read
      {3'd2, 1'b1, 16'hFFFF, 16'hC33C, 8'h3C, 4'd4},  // R4 cap lo, loads C3
      {3'd3, 1'b1, 16'hFFFF, 16'h0000, 8'hC3, 4'd5},  // R5
      {3'd1, 1'b1, 16'hFFFF, 16'h0000, 8'hC3, 4'd6},  // R6 cap byte at cnt hi
      {3'd0, 1'b0, 16'h7788, 16'h0000, 8'h00, 4'd8},  // R8 no strobe, zero data
      {3'd1, 1'b1, 16'h7788, 16'h0000, 8'hC3, 4'd8},  // R8 no load happened
      {3'd1, 1'b1, 16'h12FF, 16'h0000, 8'hC3, 4'd10}, // R10 hi first: stale
      {3'd0, 1'b1, 16'h1300, 16'h0000, 8'h00, 4'd2},  // R2 lo after borrow, loads 13
      {3'd1, 1'b1, 16'h12FF, 16'h0000, 8'h13, 4'd9},  // R9 snapshot not torn
      {3'd5, 1'b1, 16'hEEEE, 16'hDDDD, 8'h00, 4'd11}, // R11 unmapped zero
      {3'd3, 1'b1, 16'hEEEE, 16'hDDDD, 8'h13, 4'd11}  // R11 no load
   };

   task automatic check(input logic [7:0] exp, input int req);
      checks++;
      if (rd_data !== exp) begin
         fails++;
         $display("FAIL R%0d: rd_data=%02h expected=%02h", req, rd_data, exp);
      end
   endtask

   task automatic access(input logic [2:0] a, input logic r,
                         input logic [15:0] c, input logic [15:0] p,
                         input logic [7:0] exp, input int req);
      @(negedge clk);
      rd_addr = a; rd_en = r; cnt_val = c; cap_val = p;
      #1 check(exp, req);
      @(posedge clk);
      #1 rd_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R8 idle output after reset
      #1 check(8'h00, 8);
      for (int i = 0; i < NV; i++) begin
         access(VEC[i][47:45], VEC[i][44], VEC[i][43:28], VEC[i][27:12],
                VEC[i][11:4], int'(VEC[i][3:0]));
      end
      // R5 then R2 interleave: capture low, counter low overrides
      access(3'd2, 1'b1, 16'h4400, 16'h9911, 8'h11, 4);
      access(3'd0, 1'b1, 16'h4400, 16'h9911, 8'h00, 2);
      access(3'd3, 1'b1, 16'h0000, 16'h0000, 8'h44, 3);
      // R1 reset in mid-run clears holding register
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      access(3'd1, 1'b1, 16'hBEEF, 16'hCAFE, 8'h00, 1);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #40000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule